// File: doc/BRIEF.md
# Dual-Rail Pipeline Handshake Controller

This block sits between two adjacent pipeline stages and couples two four-phase handshakes. On the upstream side it receives a request and returns an acknowledge. On the downstream side it issues a request and receives an acknowledge. When the upstream request rises, the controller raises the downstream request, which tells the next stage to capture the data. In the same step it raises the upstream acknowledge. The two return-to-zero phases then run concurrently and independently. A new transfer is launched only once both phases have fully finished.

The two outputs and two internal state bits are each held as a true/false rail pair, and each pair is updated from set and reset terms. These terms are written purely in rails, so a complement is always a rail swap. A pair that changes value first drops to the all-zero spacer for exactly one clock, and then takes its new code word. Single-rail views of both outputs are provided for ordinary logic. A one-cycle pulse flags protocol violations by the environment.

Top module: `hs_dr_ctrl`

## Requirements
- R1: While reset is asserted and after its release, both output pairs read false (true rail 0, false rail 1), both single-rail views are 0 and the violation flag is 0.
- R2: A pair reads logic 1 as true=1/false=0, logic 0 as true=0/false=1, and spacer as 0/0. The pattern 1/1 never appears.
- R3: Every change of a pair's value is preceded by exactly one cycle of spacer. During spacer the single-rail view keeps the old value, and it takes the new value on the same edge as the new code word.
- R4: With the controller idle and the downstream acknowledge low, a high upstream request sampled at an edge puts both output pairs into spacer at that edge. Both read 1 one edge later.
- R5: The upstream acknowledge falls only after the upstream request has been seen low following a launched transfer.
- R6: The downstream request falls only after the downstream acknowledge has been seen high.
- R7: The upstream acknowledge is not raised again until both internal state bits have returned to 0. This holds even if the upstream request rises again early.
- R8: The violation flag pulses for one cycle, one edge after either of two events. The first is the upstream request falling while the upstream acknowledge view is 0. The second is the downstream acknowledge rising while the downstream request view is 0.
- R9: With the upstream request already held high, a new transfer launches after the downstream acknowledge falls. The output pairs enter spacer on the fifth edge after that fall is sampled, and read 1 on the sixth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_i | input | 1 | Request from the upstream stage |
| dn_ack_i | input | 1 | Acknowledge from the downstream stage |
| dn_req_t_o | output | 1 | Downstream request, true rail |
| dn_req_f_o | output | 1 | Downstream request, false rail |
| up_ack_t_o | output | 1 | Upstream acknowledge, true rail |
| up_ack_f_o | output | 1 | Upstream acknowledge, false rail |
| dn_req_o | output | 1 | Single-rail view of the downstream request |
| up_ack_o | output | 1 | Single-rail view of the upstream acknowledge |
| proto_err_o | output | 1 | One-cycle protocol violation pulse |

## Verification
The bench covers the early-request case, where the upstream request rises again after the acknowledge has fallen but while the downstream side is still returning to zero. A controller that cannot tell this state apart from idle would re-raise the acknowledge at once. The bench also counts the exact edges of the six-step relaunch and of each spacer. A design that skipped the spacer, or lingered in it, would show its code words one edge off. Every sequence of six two-bit input steps is also swept against an independent cycle model. This catches a mis-swapped rail, a stuck view, or a violation pulse on the wrong event.

// File: rtl/hs_dr_pkg.sv
package hs_dr_pkg;

  localparam int NSIG      = 4;
  localparam int SIG_DNREQ = 0;
  localparam int SIG_UPACK = 1;
  localparam int SIG_K0    = 2;
  localparam int SIG_K1    = 3;

  typedef struct packed {
    logic t;
    logic f;
  } dr_t;

  function automatic dr_t dr_of(input logic b);
    dr_t r;
    r.t = b;
    r.f = ~b;
    return r;
  endfunction

  function automatic logic dr_spacer(input dr_t p);
    return ~p.t & ~p.f;
  endfunction

  // downstream request: launch when idle and downstream quiet
  function automatic logic set_dnreq(input dr_t ri, input dr_t ai, input dr_t k0, input dr_t k1);
    return ri.t & ai.f & k0.f & k1.f;
  endfunction

  function automatic logic clr_dnreq(input dr_t ai, input dr_t k1);
    return ai.t & k1.t;
  endfunction

  // upstream acknowledge: launch only when both state bits are clear
  function automatic logic set_upack(input dr_t ri, input dr_t k0, input dr_t k1);
    return ri.t & k0.f & k1.f;
  endfunction

  function automatic logic clr_upack(input dr_t ri, input dr_t k0);
    return ri.f & k0.t;
  endfunction

  // k0 tracks the upstream side of the round
  function automatic logic set_k0(input dr_t ao);
    return ao.t;
  endfunction

  function automatic logic clr_k0(input dr_t ao, input dr_t k1);
    return ao.f & k1.f;
  endfunction

  // k1 tracks the downstream side of the round
  function automatic logic set_k1(input dr_t ro);
    return ro.t;
  endfunction

  function automatic logic clr_k1(input dr_t ro, input dr_t ai);
    return ro.f & ai.f;
  endfunction

endpackage

// File: rtl/hs_dr_cell.sv
module hs_dr_cell
  import hs_dr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output dr_t  rail_o,
  output dr_t  hold_o
);

  dr_t  rail_q;
  dr_t  hold_q;
  logic in_spacer;
  logic fire;

  assign in_spacer = dr_spacer(rail_q);
  assign fire      = (hold_q.f & set_i) | (hold_q.t & clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rail_q <= dr_of(1'b0);
      hold_q <= dr_of(1'b0);
    end else if (in_spacer) begin
      // leave spacer by rail swap of the held value
      rail_q.t <= hold_q.f;
      rail_q.f <= hold_q.t;
      hold_q.t <= hold_q.f;
      hold_q.f <= hold_q.t;
    end else if (fire) begin
      rail_q <= '0;
    end
  end

  assign rail_o = rail_q;
  assign hold_o = hold_q;

  AST_RAILS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rail_q.t && rail_q.f)); // R2
  AST_SPACER_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_spacer |=> !dr_spacer(rail_q)); // R3
  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i && clr_i)); // R3

endmodule

// File: rtl/hs_dr_next.sv
module hs_dr_next
  import hs_dr_pkg::*;
(
  input  dr_t                ri_i,
  input  dr_t                ai_i,
  input  dr_t [NSIG-1:0]     hold_i,
  output logic [NSIG-1:0]    set_o,
  output logic [NSIG-1:0]    clr_o
);

  dr_t ro, ao, k0, k1;

  always_comb begin
    ro = hold_i[SIG_DNREQ];
    ao = hold_i[SIG_UPACK];
    k0 = hold_i[SIG_K0];
    k1 = hold_i[SIG_K1];
    set_o[SIG_DNREQ] = set_dnreq(ri_i, ai_i, k0, k1);
    clr_o[SIG_DNREQ] = clr_dnreq(ai_i, k1);
    set_o[SIG_UPACK] = set_upack(ri_i, k0, k1);
    clr_o[SIG_UPACK] = clr_upack(ri_i, k0);
    set_o[SIG_K0]    = set_k0(ao);
    clr_o[SIG_K0]    = clr_k0(ao, k1);
    set_o[SIG_K1]    = set_k1(ro);
    clr_o[SIG_K1]    = clr_k1(ro, ai_i);
  end

endmodule

// File: rtl/hs_dr_front.sv
module hs_dr_front
  import hs_dr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_req_i,
  input  logic dn_ack_i,
  input  logic ao_low_i,
  input  logic ro_low_i,
  output dr_t  ri_o,
  output dr_t  ai_o,
  output logic err_o
);

  logic ri_q, ai_q, err_q;
  logic ri_fall_early;
  logic ai_rise_early;

  assign ri_o = dr_of(up_req_i);
  assign ai_o = dr_of(dn_ack_i);

  assign ri_fall_early = ri_q & ri_o.f & ao_low_i;
  assign ai_rise_early = ~ai_q & ai_o.t & ro_low_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ri_q  <= 1'b0;
      ai_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ri_q  <= up_req_i;
      ai_q  <= dn_ack_i;
      err_q <= ri_fall_early | ai_rise_early;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/hs_dr_ctrl.sv
module hs_dr_ctrl
  import hs_dr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic up_req_i,
  input  logic dn_ack_i,
  output logic dn_req_t_o,
  output logic dn_req_f_o,
  output logic up_ack_t_o,
  output logic up_ack_f_o,
  output logic dn_req_o,
  output logic up_ack_o,
  output logic proto_err_o
);

  dr_t               ri_w, ai_w;
  dr_t [NSIG-1:0]    rail_w;
  dr_t [NSIG-1:0]    hold_w;
  logic [NSIG-1:0]   set_w;
  logic [NSIG-1:0]   clr_w;
  logic              k_idle;

  hs_dr_front u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_req_i (up_req_i),
    .dn_ack_i (dn_ack_i),
    .ao_low_i (hold_w[SIG_UPACK].f),
    .ro_low_i (hold_w[SIG_DNREQ].f),
    .ri_o     (ri_w),
    .ai_o     (ai_w),
    .err_o    (proto_err_o)
  );

  hs_dr_next u_next (
    .ri_i   (ri_w),
    .ai_i   (ai_w),
    .hold_i (hold_w),
    .set_o  (set_w),
    .clr_o  (clr_w)
  );

  for (genvar g = 0; g < NSIG; g++) begin : g_cell
    hs_dr_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_w[g]),
      .clr_i  (clr_w[g]),
      .rail_o (rail_w[g]),
      .hold_o (hold_w[g])
    );

    AST_RAIL_HOLD_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_w[g].t | rail_w[g].f) |-> (rail_w[g].t == hold_w[g].t)); // R3
  end

  assign k_idle = hold_w[SIG_K0].f & hold_w[SIG_K1].f;

  assign dn_req_t_o = rail_w[SIG_DNREQ].t;
  assign dn_req_f_o = rail_w[SIG_DNREQ].f;
  assign up_ack_t_o = rail_w[SIG_UPACK].t;
  assign up_ack_f_o = rail_w[SIG_UPACK].f;
  assign dn_req_o   = hold_w[SIG_DNREQ].t;
  assign up_ack_o   = hold_w[SIG_UPACK].t;

  AST_LAUNCH_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req_o) |-> $past(up_req_i, 2)); // R4
  AST_ACK_FALL_AFTER_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_ack_o) |-> !$past(up_req_i, 2)); // R5
  AST_REQ_FALL_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_req_o) |-> $past(dn_ack_i, 2)); // R6
  AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_ack_o) |-> $past(k_idle, 2)); // R7

endmodule

// File: tb/hs_dr_ctrl_tb.sv
`timescale 1ns/1ps
module hs_dr_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0;
  logic dn_ack = 1'b0;
  logic dn_req_t, dn_req_f, up_ack_t, up_ack_f, dn_req, up_ack, perr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // independent cycle model: value, spacer flag per signal (0 Ro,1 Ao,2 k0,3 k1)
  logic [3:0] mv, msp;
  logic mri_q, mai_q, merr;

  always #2.5 clk = ~clk;

  hs_dr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .up_req_i(up_req), .dn_ack_i(dn_ack),
    .dn_req_t_o(dn_req_t), .dn_req_f_o(dn_req_f),
    .up_ack_t_o(up_ack_t), .up_ack_f_o(up_ack_f),
    .dn_req_o(dn_req), .up_ack_o(up_ack), .proto_err_o(perr)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic mdl_reset();
    mv = '0; msp = '0; mri_q = 1'b0; mai_q = 1'b0; merr = 1'b0;
  endtask

  task automatic cmp_model();
    logic [7:0] e;
    e = {1'b0, mv[0] & ~msp[0], ~mv[0] & ~msp[0], mv[1] & ~msp[1], ~mv[1] & ~msp[1], mv[0], mv[1], merr};
    chk("R3 rails/views vs model", {1'b0, dn_req_t, dn_req_f, up_ack_t, up_ack_f, dn_req, up_ack, perr}, e);
    chk("R2 no 1/1 pair", {6'd0, dn_req_t & dn_req_f, up_ack_t & up_ack_f}, 8'd0);
  endtask

  // called at a negedge: drive, advance one edge, compare at next negedge
  task automatic cyc(input logic ri, input logic ai);
    logic [3:0] s, r, nv, nsp;
    logic nerr;
    up_req = ri; dn_ack = ai;
    s[0] = ri && !ai && !mv[2] && !mv[3];  r[0] = ai && mv[3];
    s[1] = ri && !mv[2] && !mv[3];         r[1] = !ri && mv[2];
    s[2] = mv[1];                          r[2] = !mv[1] && !mv[3];
    s[3] = mv[0];                          r[3] = !mv[0] && !ai;
    for (int i = 0; i < 4; i++) begin
      nv[i] = mv[i]; nsp[i] = 1'b0;
      if (msp[i]) nv[i] = ~mv[i];
      else if ((!mv[i] && s[i]) || (mv[i] && r[i])) nsp[i] = 1'b1;
    end
    nerr = (mri_q && !ri && !mv[1]) || (!mai_q && ai && !mv[0]);
    @(posedge clk);
    #1;
    mv = nv; msp = nsp; merr = nerr; mri_q = ri; mai_q = ai;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic do_reset();
    up_req = 1'b0; dn_ack = 1'b0; rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mdl_reset();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    mdl_reset();
    @(negedge clk);
    @(negedge clk);
    // R1 during reset
    chk("R1 in reset", {1'b0, dn_req_t, dn_req_f, up_ack_t, up_ack_f, dn_req, up_ack, perr}, 8'b0010_1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {1'b0, dn_req_t, dn_req_f, up_ack_t, up_ack_f, dn_req, up_ack, perr}, 8'b0010_1000);

    // legal round with an early second request
    cyc(1, 0);
    chk("R4 spacer at launch", {4'd0, dn_req_t, dn_req_f, up_ack_t, up_ack_f}, 8'b0000_0000);
    cyc(1, 0);
    chk("R4 both high", {4'd0, dn_req_t, dn_req_f, up_ack_t, up_ack_f}, 8'b0000_1010);
    cyc(0, 0);
    cyc(0, 0);
    chk("R5 ack holds until state set", {7'd0, up_ack}, 8'd1);
    cyc(0, 0);
    chk("R5 ack spacer", {6'd0, up_ack_t, up_ack_f}, 8'd0);
    cyc(1, 0);
    chk("R5 ack low", {6'd0, up_ack_t, up_ack_f}, 8'b01);
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0);
      chk("R7 no early ack", {6'd0, up_ack, dn_req}, 8'b01);
    end
    cyc(1, 1);
    chk("R6 req spacer", {6'd0, dn_req_t, dn_req_f}, 8'd0);
    cyc(1, 1);
    chk("R6 req low", {6'd0, dn_req_t, dn_req_f}, 8'b01);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 0);
      chk("R7 ack held during state return", {6'd0, up_ack_t, up_ack_f}, 8'b01);
    end
    cyc(1, 0);
    chk("R9 relaunch spacer", {4'd0, dn_req_t, dn_req_f, up_ack_t, up_ack_f}, 8'd0);
    cyc(1, 0);
    chk("R9 relaunch high", {4'd0, dn_req_t, dn_req_f, up_ack_t, up_ack_f}, 8'b1010);

    // violations
    do_reset();
    cyc(1, 0);
    cyc(0, 0);
    chk("R8 early request drop", {7'd0, perr}, 8'd1);
    cyc(0, 0);
    chk("R8 pulse one cycle", {7'd0, perr}, 8'd0);
    do_reset();
    cyc(0, 1);
    chk("R8 ack without request", {7'd0, perr}, 8'd1);

    // exhaustive sweep of six two-bit steps, each held three edges
    for (int code = 0; code < 4096; code++) begin
      do_reset();
      for (int st = 0; st < 6; st++) begin
        for (int h = 0; h < 3; h++) begin
          cyc(code[2*st+1], code[2*st]);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule